// File: doc/BRIEF.md
# Timestamp-Addressed Hit Sorting Buffer

This block puts a stream of detector hits back into time order when they arrive somewhat late and out of sequence. Each hit carries a timestamp made of a frame number (upper bits) and a sub-frame fine time (lower bits). The frame number selects a region of an internal memory, and the hit goes into the next free slot of that frame. No comparisons between hits are made. Ordering comes entirely from where a hit is written.

The frame space has 64 frames, grouped into four blocks of 16. A free-running frame pointer advances on each `frameTick` pulse. Hits are accepted only for the block that holds the pointer and for the block just before it. A hit delayed by up to 16 frames therefore still lands in place. When the pointer crosses into a new block, the block two positions behind it is complete. That block is streamed out frame by frame, and each frame's slot counter is cleared as its end marker goes out. The remaining block sits idle and empty until the pointer reaches it again.

For normal use, frame ticks must be spaced far enough apart that a readout (16 markers plus the stored hits) finishes before the next block crossing.

Top module: `hit_time_sorter`

## Requirements
- R1: After reset, `outValid`, `outEnd`, `dropFull` and `dropLate` are 0, `outTs`/`outAddr` are 0, every frame is empty, and the frame pointer is 0.
- R2: The frame of a hit is `hitTs[9:4]`, its block is `hitTs[9:8]` and its fine time is `hitTs[3:0]`. A hit whose block equals the pointer's block, or the block one below it (modulo 4), is stored in its frame.
- R3: A frame holds at most 32 hits. A hit for a full frame is not stored and raises `dropFull` for exactly the cycle after the hit. Other frames are unaffected.
- R4: An accepted hit, including a late one for the previous block, never raises `dropLate`.
- R5: A hit whose block is neither the pointer's block nor the one below it is discarded and raises `dropLate` for the cycle after the hit.
- R6: `dropFull` and `dropLate` are only ever high in the cycle after a cycle with `hitValid` high.
- R7: A `frameTick` that moves the pointer from frame index 15 of a block into the next block starts the readout of the block two below the new one. The first output event appears on the clock edge after the tick edge.
- R8: The readout visits the 16 frames in increasing order. For each frame it emits the stored hits in arrival order (`outValid` high, `outTs` = {frame, fine time}, `outAddr` = the hit address) and then one marker (`outEnd` high, `outTs` = {frame, 0}, `outAddr` = 0). Consecutive markers name consecutive frames.
- R9: At most one event is presented per cycle: `outValid` and `outEnd` are never high together.
- R10: A frame's count is cleared when its marker is emitted. When the pointer next wraps onto that frame, it holds only hits written after that readout.
- R11: The frame pointer wraps from 63 to 0, so block 0 follows block 3 in both acceptance and readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hitValid | input | 1 | A hit is present this cycle |
| hitTs | input | 10 | Hit timestamp: frame in [9:4], fine time in [3:0] |
| hitAddr | input | 10 | Hit pixel address carried through unchanged |
| frameTick | input | 1 | Advances the frame pointer by one |
| outValid | output | 1 | Sorted hit on the output |
| outEnd | output | 1 | End-of-frame marker on the output |
| outTs | output | 10 | Timestamp of the hit, or {frame, 0} for a marker |
| outAddr | output | 10 | Address of the hit, 0 for a marker |
| dropFull | output | 1 | Previous hit lost because its frame was full |
| dropLate | output | 1 | Previous hit lost because its block was outside the window |

## Verification
Some properties are checked on every cycle. These are the acceptance window against an independently tracked frame pointer, the drop flags following only hit cycles, readout events coming only from the block two below the current one, markers carrying a zero fine time and naming consecutive frames, and the exclusiveness of hit and marker outputs. Other behaviour can only be shown by the bench's scenarios, because each of these depends on what was written many frames earlier. This covers the stored contents and arrival order within each frame, the 32-hit limit, the start latency of readout, the wrap of the pointer, and the clearing of frames so that a reused frame shows only new hits.

// File: rtl/hts_pkg.sv
package hts_pkg;
  parameter int FRAME_W = 6;
  parameter int SUB_W   = 4;
  parameter int ADDR_W  = 10;
  parameter int SLOT_N  = 32;
  parameter int BLK_W   = 2;

  localparam int TS_W    = FRAME_W + SUB_W;
  localparam int SLOT_W  = $clog2(SLOT_N);
  localparam int CNT_W   = SLOT_W + 1;
  localparam int FRAME_N = 1 << FRAME_W;
  localparam int FIB_W   = FRAME_W - BLK_W;
  localparam int ENTRY_W = SUB_W + ADDR_W;
  localparam int MEM_AW  = FRAME_W + SLOT_W;

  typedef struct packed {
    logic               wrEn;
    logic               clrEn;
    logic               emitHit;
    logic               emitEnd;
    logic [FRAME_W-1:0] rdFrame;
    logic [SLOT_W-1:0]  rdSlot;
  } strobe_t;
endpackage

// File: rtl/hit_time_sorter_ctrl.sv
module hit_time_sorter_ctrl
  import hts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hitValid,
  input  logic [BLK_W-1:0] hitBlk,
  input  logic             frameTick,
  input  logic             wrFull,
  input  logic [CNT_W-1:0] rdCount,
  output strobe_t          strobes,
  output logic             dropFull,
  output logic             dropLate
);
  logic [FRAME_W-1:0] curFrame;
  logic [BLK_W-1:0]   curBlk;
  logic               inWindow;
  logic               blockEdge;
  logic               busy;
  logic [FRAME_W-1:0] rdFrame;
  logic [CNT_W-1:0]   rdSlotCnt;
  logic               haveHit;
  logic               lastFrame;

  assign curBlk    = curFrame[FRAME_W-1 -: BLK_W];
  assign inWindow  = (hitBlk == curBlk) || (hitBlk == BLK_W'(curBlk - 1'b1));
  assign blockEdge = frameTick && (curFrame[FIB_W-1:0] == '1);
  assign haveHit   = busy && (rdSlotCnt < rdCount);
  assign lastFrame = (rdFrame[FIB_W-1:0] == '1);

  always_comb begin
    strobes.wrEn    = hitValid && inWindow && !wrFull;
    strobes.emitHit = haveHit;
    strobes.emitEnd = busy && !haveHit;
    strobes.clrEn   = busy && !haveHit;
    strobes.rdFrame = rdFrame;
    strobes.rdSlot  = rdSlotCnt[SLOT_W-1:0];
  end

  // frame pointer and drop reporting
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curFrame <= '0;
      dropFull <= 1'b0;
      dropLate <= 1'b0;
    end else begin
      if (frameTick) curFrame <= curFrame + 1'b1;
      dropFull <= hitValid && inWindow && wrFull;
      dropLate <= hitValid && !inWindow;
    end
  end

  // readout walker over the completed block
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rdFrame   <= '0;
      rdSlotCnt <= '0;
    end else if (blockEdge) begin
      busy      <= 1'b1;
      rdFrame   <= {BLK_W'(curBlk - 1'b1), FIB_W'(0)};
      rdSlotCnt <= '0;
    end else if (busy) begin
      if (haveHit) begin
        rdSlotCnt <= rdSlotCnt + 1'b1;
      end else begin
        rdSlotCnt <= '0;
        rdFrame   <= rdFrame + 1'b1;
        if (lastFrame) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hit_time_sorter_dp.sv
module hit_time_sorter_dp
  import hts_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strobes,
  input  logic [FRAME_W-1:0] hitFrame,
  input  logic [SUB_W-1:0]   hitSub,
  input  logic [ADDR_W-1:0]  hitAddr,
  output logic               wrFull,
  output logic [CNT_W-1:0]   rdCount,
  output logic               outValid,
  output logic               outEnd,
  output logic [TS_W-1:0]    outTs,
  output logic [ADDR_W-1:0]  outAddr
);
  logic [CNT_W-1:0]   frameCnt [FRAME_N];
  logic [ENTRY_W-1:0] hitMem   [FRAME_N*SLOT_N];
  logic [CNT_W-1:0]   wrCount;
  logic [MEM_AW-1:0]  wrIdx;
  logic [MEM_AW-1:0]  rdIdx;
  logic [ENTRY_W-1:0] rdEntry;

  for (genvar g = 0; g < FRAME_N; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        frameCnt[g] <= '0;
      else if (strobes.clrEn && strobes.rdFrame == FRAME_W'(g))
        frameCnt[g] <= '0;
      else if (strobes.wrEn && hitFrame == FRAME_W'(g))
        frameCnt[g] <= frameCnt[g] + 1'b1;
    end
  end

  assign wrCount = frameCnt[hitFrame];
  assign wrFull  = (wrCount == CNT_W'(SLOT_N));
  assign rdCount = frameCnt[strobes.rdFrame];
  assign wrIdx   = {hitFrame, wrCount[SLOT_W-1:0]};
  assign rdIdx   = {strobes.rdFrame, strobes.rdSlot};
  assign rdEntry = hitMem[rdIdx];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) hitMem[wrIdx] <= {hitSub, hitAddr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outEnd   <= 1'b0;
      outTs    <= '0;
      outAddr  <= '0;
    end else begin
      outValid <= strobes.emitHit;
      outEnd   <= strobes.emitEnd;
      if (strobes.emitHit) begin
        outTs   <= {strobes.rdFrame, rdEntry[ENTRY_W-1 -: SUB_W]};
        outAddr <= rdEntry[ADDR_W-1:0];
      end else begin
        outTs   <= {strobes.rdFrame, SUB_W'(0)};
        outAddr <= '0;
      end
    end
  end
endmodule

// File: rtl/hit_time_sorter.sv
module hit_time_sorter
  import hts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hitValid,
  input  logic [TS_W-1:0]   hitTs,
  input  logic [ADDR_W-1:0] hitAddr,
  input  logic              frameTick,
  output logic              outValid,
  output logic              outEnd,
  output logic [TS_W-1:0]   outTs,
  output logic [ADDR_W-1:0] outAddr,
  output logic              dropFull,
  output logic              dropLate
);
  strobe_t          strobes;
  logic             wrFull;
  logic [CNT_W-1:0] rdCount;

  hit_time_sorter_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hitValid  (hitValid),
    .hitBlk    (hitTs[TS_W-1 -: BLK_W]),
    .frameTick (frameTick),
    .wrFull    (wrFull),
    .rdCount   (rdCount),
    .strobes   (strobes),
    .dropFull  (dropFull),
    .dropLate  (dropLate)
  );

  hit_time_sorter_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .hitFrame (hitTs[TS_W-1 -: FRAME_W]),
    .hitSub   (hitTs[SUB_W-1:0]),
    .hitAddr  (hitAddr),
    .wrFull   (wrFull),
    .rdCount  (rdCount),
    .outValid (outValid),
    .outEnd   (outEnd),
    .outTs    (outTs),
    .outAddr  (outAddr)
  );
endmodule

// File: rtl/hit_time_sorter_chk.sv
module hit_time_sorter_chk
  import hts_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hitValid,
  input logic [BLK_W-1:0] hitBlk,
  input logic             frameTick,
  input logic             outValid,
  input logic             outEnd,
  input logic [TS_W-1:0]  outTs,
  input logic             dropFull,
  input logic             dropLate
);
  logic [FRAME_W-1:0] chkFrame;
  logic [FRAME_W-1:0] lastEnd;
  logic               seenEnd;
  logic [BLK_W-1:0]   chkBlk;
  logic               outside;
  logic [FRAME_W-1:0] outFrame;

  assign chkBlk   = chkFrame[FRAME_W-1 -: BLK_W];
  assign outside  = (hitBlk != chkBlk) && (hitBlk != BLK_W'(chkBlk - 1'b1));
  assign outFrame = outTs[TS_W-1 -: FRAME_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chkFrame <= '0;
      lastEnd  <= '0;
      seenEnd  <= 1'b0;
    end else begin
      if (frameTick) chkFrame <= chkFrame + 1'b1;
      if (outEnd) begin
        lastEnd <= outFrame;
        seenEnd <= 1'b1;
      end
    end
  end

  assert_late_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hitValid && outside |=> dropLate);

  assert_window_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hitValid && !outside |=> !dropLate);

  assert_drop_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dropFull || dropLate) |-> $past(hitValid));

  assert_read_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid || outEnd) |-> outTs[TS_W-1 -: BLK_W] == BLK_W'(chkBlk - 2'd2));

  assert_frame_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outEnd && seenEnd |-> outFrame == FRAME_W'(lastEnd + 1'b1));

  assert_marker_fine_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outEnd |-> outTs[SUB_W-1:0] == '0);

  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(outValid && outEnd));
endmodule

bind hit_time_sorter hit_time_sorter_chk chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hitValid  (hitValid),
  .hitBlk    (hitTs[hts_pkg::TS_W-1 -: hts_pkg::BLK_W]),
  .frameTick (frameTick),
  .outValid  (outValid),
  .outEnd    (outEnd),
  .outTs     (outTs),
  .dropFull  (dropFull),
  .dropLate  (dropLate)
);

// File: tb/tb_hit_time_sorter.sv
module tb_hit_time_sorter;
  import hts_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hitValid = 1'b0;
  logic [TS_W-1:0]   hitTs = '0;
  logic [ADDR_W-1:0] hitAddr = '0;
  logic              frameTick = 1'b0;
  logic              outValid, outEnd, dropFull, dropLate;
  logic [TS_W-1:0]   outTs;
  logic [ADDR_W-1:0] outAddr;

  always #4 clk = ~clk;

  hit_time_sorter dut (
    .clk(clk), .rst_n(rst_n), .hitValid(hitValid), .hitTs(hitTs),
    .hitAddr(hitAddr), .frameTick(frameTick), .outValid(outValid),
    .outEnd(outEnd), .outTs(outTs), .outAddr(outAddr),
    .dropFull(dropFull), .dropLate(dropLate)
  );

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  // bench model of the stored frames
  int                mCnt  [FRAME_N];
  logic [ADDR_W-1:0] mAddr [FRAME_N][SLOT_N];
  logic [SUB_W-1:0]  mSub  [FRAME_N][SLOT_N];
  int                mFrame = 0;

  // {expected late, frame(6), fine(4), addr(10)}; pointer at frame 0
  localparam logic [TS_W+ADDR_W:0] VEC [8] = '{
    {1'b0, 6'd5,  4'd3,  10'h101},
    {1'b0, 6'd2,  4'd9,  10'h102},
    {1'b1, 6'd17, 4'd0,  10'h1FF},
    {1'b0, 6'd5,  4'd1,  10'h103},
    {1'b0, 6'd60, 4'd7,  10'h104},
    {1'b1, 6'd33, 4'd2,  10'h1EE},
    {1'b0, 6'd0,  4'd15, 10'h105},
    {1'b0, 6'd2,  4'd0,  10'h106}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit modelLate(input int f);
    int hb = f >> FIB_W;
    int cb = mFrame >> FIB_W;
    int nb = 1 << BLK_W;
    return !(hb == cb || hb == (cb + nb - 1) % nb);
  endfunction

  task automatic sendHit(input int f, input int sub, input int addr,
                         input bit expLate, input string req);
    bit expFull = !expLate && (mCnt[f] == SLOT_N);
    hitValid = 1'b1;
    hitTs    = {FRAME_W'(f), SUB_W'(sub)};
    hitAddr  = ADDR_W'(addr);
    @(negedge clk);
    hitValid = 1'b0;
    check(dropLate == expLate, req, "dropLate", int'(dropLate), int'(expLate));
    check(dropFull == expFull, req, "dropFull", int'(dropFull), int'(expFull));
    if (!expLate && !expFull) begin
      mAddr[f][mCnt[f]] = ADDR_W'(addr);
      mSub[f][mCnt[f]]  = SUB_W'(sub);
      mCnt[f]++;
    end
  endtask

  task automatic waitEvent(output int waited);
    waited = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      waited++;
      if (outValid || outEnd) return;
    end
    check(1'b0, "R7", "event timeout", 0, 1);
  endtask

  task automatic readBlock(input int rb);
    int w;
    bit first = 1;
    for (int f = rb * (1 << FIB_W); f < (rb + 1) * (1 << FIB_W); f++) begin
      for (int i = 0; i < mCnt[f]; i++) begin
        waitEvent(w);
        if (first) check(w == 1, "R7", "readout start latency", w, 1);
        first = 0;
        check(!(outValid && outEnd), "R9", "hit and marker together", int'(outEnd), 0);
        check(outValid == 1'b1, "R8", "hit expected", int'(outValid), 1);
        check(outTs == {FRAME_W'(f), mSub[f][i]}, "R8", "hit ts",
              int'(outTs), int'({FRAME_W'(f), mSub[f][i]}));
        check(outAddr == mAddr[f][i], "R8", "hit addr", int'(outAddr), int'(mAddr[f][i]));
      end
      waitEvent(w);
      if (first) check(w == 1, "R7", "readout start latency", w, 1);
      first = 0;
      check(outEnd == 1'b1 && outValid == 1'b0, "R8", "marker expected",
            int'(outEnd), 1);
      check(outTs == {FRAME_W'(f), SUB_W'(0)}, "R8", "marker ts",
            int'(outTs), int'({FRAME_W'(f), SUB_W'(0)}));
      mCnt[f] = 0;
    end
  endtask

  task automatic tick();
    frameTick = 1'b1;
    @(negedge clk);
    frameTick = 1'b0;
    check(!dropLate && !dropFull, "R6", "drop without hit",
          int'(dropLate) + int'(dropFull), 0);
    mFrame = (mFrame + 1) % FRAME_N;
    if (mFrame % (1 << FIB_W) == 0)
      readBlock(((mFrame >> FIB_W) + 2) % (1 << BLK_W));
    else
      repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < FRAME_N; f++) mCnt[f] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!outValid && !outEnd && outTs == '0 && outAddr == '0, "R1", "outputs idle",
          int'(outValid) + int'(outEnd) + int'(outTs) + int'(outAddr), 0);
    check(!dropFull && !dropLate, "R1", "drop flags idle",
          int'(dropFull) + int'(dropLate), 0);

    // table walk: R2 acceptance window, R4 kept, R5 discarded
    for (int v = 0; v < 8; v++) begin
      logic [TS_W+ADDR_W:0] e = VEC[v];
      int fr = int'(e[TS_W+ADDR_W-1 -: FRAME_W]);
      check(e[TS_W+ADDR_W] == modelLate(fr), "R2", "table window rule",
            int'(e[TS_W+ADDR_W]), int'(modelLate(fr)));
      sendHit(fr, int'(e[ADDR_W+SUB_W-1 -: SUB_W]), int'(e[ADDR_W-1:0]),
              e[TS_W+ADDR_W], e[TS_W+ADDR_W] ? "R5" : "R4");
    end

    // into block 1: reads block 3 (R7, R8)
    repeat (16) tick();

    // late hit for previous block kept (R4); read or future block dropped (R5)
    sendHit(3, 6, 'h111, 1'b0, "R4");
    sendHit(50, 1, 'h112, 1'b1, "R5");
    sendHit(40, 1, 'h113, 1'b1, "R5");

    // R3: capacity of one frame
    for (int i = 0; i < SLOT_N + 1; i++) sendHit(20, i % 16, 'h200 + i, 1'b0, "R3");
    sendHit(21, 4, 'h300, 1'b0, "R3");

    repeat (16) tick();   // block 2: read block 0
    repeat (16) tick();   // block 3: read block 1 (full frame 20)
    repeat (16) tick();   // wrap to block 0 (R11): read block 2
    check(mFrame == 0, "R11", "pointer wrap", mFrame, 0);

    // R11: after wrap block 0 is current, block 1 is outside
    sendHit(5, 2, 'h2AA, 1'b0, "R11");
    sendHit(20, 0, 'h2BB, 1'b1, "R11");

    // R10: reused frames 3 and 5 show only new hits
    check(mCnt[3] == 0 && mCnt[5] == 1, "R10", "model reuse state", mCnt[5], 1);
    repeat (32) tick();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule